// File: doc/BRIEF.md
# Open-Addressed Filter Table Engine

This block owns one filter table of power-of-two size and serves insert, lookup, delete and clear commands against it. Each command brings a filter type, a 96-bit match word, a queue id and a precomputed hash and stride. The engine probes the table one slot per clock. It starts at the slot picked by the hash and steps by the stride, and it stops after a fixed hop cap. For every slot it holds a used flag and the stored filter.

For each filter type the engine keeps the deepest probe depth that any successful insert has needed. When an insert pushes that high-water mark up, the engine emits a search limit for the downstream lookup hardware. The limit is the new depth plus a pipeline margin: a small margin for full-match types and a larger one for wildcard types. The high-water marks return to zero when the table becomes empty.

Commands arrive over a valid/ready handshake with at most one in flight. The result is returned as a one-cycle response pulse that carries a status, the slot index and the probe depth.

Top module: `filter_table_engine`

## Requirements
- R1: A probe sequence starts at slot `hash & (SIZE-1)` with depth 1 and advances to `(slot + stride) & (SIZE-1)`, one slot per clock. A hit at depth d raises the response d cycles after the accepting edge. A clear raises it SIZE cycles after that edge.
- R2: An insert stops at the first probed slot that is either unused or holds an equal filter. When that slot is unused, the filter is stored there and the response has status OK (0) with that slot index.
- R3: An insert that reaches a used slot holding an equal filter returns EXISTS (3) and leaves the table unchanged when cmd_replace_i is 0. When cmd_replace_i is 1 it returns OK (0) and rewrites the slot, and the used count does not change.
- R4: Two filters are equal when their types and all 96 match bits agree. When TX_DIR is 1, their queue ids must also agree.
- R5: A lookup returns OK with the slot index and depth of the equal filter it reaches. It skips unused slots along the way.
- R6: A probe that reaches depth MAX_HOPS without success ends with index 0 and depth MAX_HOPS. The status is BUSY (1) for an insert and NOT_FOUND (2) for a lookup or delete.
- R7: A delete of a stored filter returns OK and frees its slot, so that a later lookup of the same filter returns NOT_FOUND.
- R8: When a successful insert's depth exceeds the stored maximum for its type, lim_valid_o pulses in the response cycle. lim_type_o carries the type and lim_value_o carries depth+FUDGE_FULL for full types (type bit 0 = 0) or depth+FUDGE_WILD for wildcard types (type bit 0 = 1). Otherwise lim_valid_o stays low.
- R9: A delete that leaves zero used entries resets every type's maximum depth to 0.
- R10: A clear (op 3) empties all slots, resets the used count and all maximum depths, and responds OK with index 0 and depth 0.
- R11: Op codes are lookup 0, insert 1, delete 2 and clear 3. cmd_ready_o is high only while idle, and it is low during the one-cycle rsp_valid_o pulse. Out of reset, the block is ready with no response and no limit pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Engine idle, command accepted when valid |
| cmd_op_i | input | 2 | Operation code |
| cmd_replace_i | input | 1 | Insert may overwrite an equal filter |
| cmd_type_i | input | 2 | Filter type, bit 0 set for wildcard |
| cmd_match_i | input | 96 | Match words |
| cmd_qid_i | input | 12 | Queue id |
| cmd_hash_i | input | HASH_W | Precomputed hash |
| cmd_stride_i | input | HASH_W | Probe stride |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_status_o | output | 2 | OK, BUSY, NOT_FOUND, EXISTS |
| rsp_index_o | output | log2(SIZE) | Slot index |
| rsp_depth_o | output | log2(MAX_HOPS+1) | Probe depth at completion |
| lim_valid_o | output | 1 | New search limit pulse |
| lim_type_o | output | 2 | Type whose limit changed |
| lim_value_o | output | log2(MAX_HOPS+1)+1 | Search limit value |

## Verification
A successful insert that raises its type's high-water mark produces the limit pulse and the response in the same clock. The bench provokes this by chaining colliding inserts, where each one lands deeper than the last. It then checks every cycle that both pulses appear together and only at the predicted latency. Replacing inserts and inserts that land shallower than the mark must leave the limit pulse low. The second coincidence is a delete that empties the table while responding, which resets the high-water marks. It is judged by the next shallow insert, which must emit a limit again.

// File: rtl/fte_pkg.sv
package fte_pkg;
  localparam int TYPE_W  = 2;
  localparam int MATCH_W = 96;
  localparam int QID_W   = 12;

  typedef enum logic [1:0] {
    OP_LOOKUP = 2'd0,
    OP_INSERT = 2'd1,
    OP_DELETE = 2'd2,
    OP_CLEAR  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_OK     = 2'd0,
    ST_BUSY   = 2'd1,
    ST_MISS   = 2'd2,
    ST_EXISTS = 2'd3
  } status_e;

  typedef struct packed {
    logic [TYPE_W-1:0]  ftype;
    logic [MATCH_W-1:0] words;
    logic [QID_W-1:0]   qid;
  } spec_t;
endpackage

// File: rtl/fte_slot_store.sv
module fte_slot_store import fte_pkg::*; #(
  parameter int SIZE  = 16,
  parameter int IDX_W = $clog2(SIZE)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_used_o,
  output spec_t            rd_spec_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_used_i,
  input  spec_t            wr_spec_i
);
  logic [SIZE-1:0] used_v;
  spec_t           spec_v [SIZE];

  for (genvar s = 0; s < SIZE; s++) begin : g_slot
    logic  used_q;
    spec_t spec_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        used_q <= 1'b0;
        spec_q <= '0;
      end else if (wr_en_i && wr_idx_i == IDX_W'(s)) begin
        used_q <= wr_used_i;
        spec_q <= wr_spec_i;
      end
    end
    assign used_v[s] = used_q;
    assign spec_v[s] = spec_q;
  end

  assign rd_used_o = used_v[rd_idx_i];
  assign rd_spec_o = spec_v[rd_idx_i];
endmodule

// File: rtl/fte_depth_track.sv
module fte_depth_track import fte_pkg::*; #(
  parameter int DEPTH_W    = 8,
  parameter int LIM_W      = 9,
  parameter int FUDGE_FULL = 1,
  parameter int FUDGE_WILD = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               upd_i,
  input  logic [TYPE_W-1:0]  upd_type_i,
  input  logic [DEPTH_W-1:0] upd_depth_i,
  input  logic               clr_i,
  output logic               lim_valid_o,
  output logic [TYPE_W-1:0]  lim_type_o,
  output logic [LIM_W-1:0]   lim_value_o
);
  localparam int NT = 1 << TYPE_W;

  logic [DEPTH_W-1:0] max_q [NT];
  logic               grow;
  logic [LIM_W-1:0]   fudge;

  assign grow  = upd_i && (upd_depth_i > max_q[upd_type_i]);
  assign fudge = upd_type_i[0] ? LIM_W'(FUDGE_WILD) : LIM_W'(FUDGE_FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int t = 0; t < NT; t++) max_q[t] <= '0;
    end else if (clr_i) begin
      for (int t = 0; t < NT; t++) max_q[t] <= '0;
    end else if (grow) begin
      max_q[upd_type_i] <= upd_depth_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_valid_o <= 1'b0;
      lim_type_o  <= '0;
      lim_value_o <= '0;
    end else begin
      lim_valid_o <= grow;
      if (grow) begin
        lim_type_o  <= upd_type_i;
        lim_value_o <= LIM_W'(upd_depth_i) + fudge;
      end
    end
  end
endmodule

// File: rtl/filter_table_engine.sv
module filter_table_engine import fte_pkg::*; #(
  parameter int SIZE       = 16,
  parameter int MAX_HOPS   = 200,
  parameter int HASH_W     = 16,
  parameter bit TX_DIR     = 1'b0,
  parameter int FUDGE_FULL = 1,
  parameter int FUDGE_WILD = 3,
  localparam int IDX_W     = $clog2(SIZE),
  localparam int DEPTH_W   = $clog2(MAX_HOPS + 1),
  localparam int LIM_W     = DEPTH_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  output logic               cmd_ready_o,
  input  logic [1:0]         cmd_op_i,
  input  logic               cmd_replace_i,
  input  logic [TYPE_W-1:0]  cmd_type_i,
  input  logic [MATCH_W-1:0] cmd_match_i,
  input  logic [QID_W-1:0]   cmd_qid_i,
  input  logic [HASH_W-1:0]  cmd_hash_i,
  input  logic [HASH_W-1:0]  cmd_stride_i,
  output logic               rsp_valid_o,
  output logic [1:0]         rsp_status_o,
  output logic [IDX_W-1:0]   rsp_index_o,
  output logic [DEPTH_W-1:0] rsp_depth_o,
  output logic               lim_valid_o,
  output logic [TYPE_W-1:0]  lim_type_o,
  output logic [LIM_W-1:0]   lim_value_o
);
  localparam int CNT_W = $clog2(SIZE + 1);

  typedef enum logic [1:0] {S_IDLE, S_PROBE, S_CLEAR, S_DONE} state_e;

  state_e             state_q;
  op_e                op_q;
  logic               rep_q;
  spec_t              spec_q;
  logic [IDX_W-1:0]   stride_q, idx_q;
  logic [DEPTH_W-1:0] depth_q;
  logic [CNT_W-1:0]   cnt_q;
  status_e            status_q;
  logic [IDX_W-1:0]   rsp_idx_q;
  logic [DEPTH_W-1:0] rsp_depth_q;

  logic  rd_used;
  spec_t rd_spec;
  logic  match_eq, hit, take, give_up, ins_ok, del_ok, clr_last, wr_en, depth_clr;
  logic  unused_bits;

  assign unused_bits = ^{cmd_hash_i[HASH_W-1:IDX_W], cmd_stride_i[HASH_W-1:IDX_W]};

  assign match_eq = (rd_spec.ftype == spec_q.ftype) && (rd_spec.words == spec_q.words) &&
                    (!TX_DIR || rd_spec.qid == spec_q.qid);
  assign hit      = rd_used ? match_eq : (op_q == OP_INSERT);
  assign take     = (state_q == S_PROBE) && hit;
  assign give_up  = (state_q == S_PROBE) && !hit && (depth_q == DEPTH_W'(MAX_HOPS));
  assign ins_ok   = take && (op_q == OP_INSERT) && (!rd_used || rep_q);
  assign del_ok   = take && (op_q == OP_DELETE);
  assign clr_last = (state_q == S_CLEAR) && (idx_q == IDX_W'(SIZE - 1));
  assign wr_en    = ins_ok || del_ok || (state_q == S_CLEAR);
  // table empties when the last used entry is removed
  assign depth_clr = clr_last || (del_ok && cnt_q == CNT_W'(1));

  fte_slot_store #(.SIZE(SIZE)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (idx_q),
    .rd_used_o(rd_used),
    .rd_spec_o(rd_spec),
    .wr_en_i  (wr_en),
    .wr_idx_i (idx_q),
    .wr_used_i(ins_ok),
    .wr_spec_i(ins_ok ? spec_q : '0)
  );

  fte_depth_track #(
    .DEPTH_W   (DEPTH_W),
    .LIM_W     (LIM_W),
    .FUDGE_FULL(FUDGE_FULL),
    .FUDGE_WILD(FUDGE_WILD)
  ) u_depth (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_i      (ins_ok),
    .upd_type_i (spec_q.ftype),
    .upd_depth_i(depth_q),
    .clr_i      (depth_clr),
    .lim_valid_o(lim_valid_o),
    .lim_type_o (lim_type_o),
    .lim_value_o(lim_value_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_last) begin
      cnt_q <= '0;
    end else if (ins_ok && !rd_used) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end else if (del_ok) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      op_q        <= OP_LOOKUP;
      rep_q       <= 1'b0;
      spec_q      <= '0;
      stride_q    <= '0;
      idx_q       <= '0;
      depth_q     <= '0;
      status_q    <= ST_OK;
      rsp_idx_q   <= '0;
      rsp_depth_q <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (cmd_valid_i) begin
          op_q     <= op_e'(cmd_op_i);
          rep_q    <= cmd_replace_i;
          spec_q   <= '{ftype: cmd_type_i, words: cmd_match_i, qid: cmd_qid_i};
          stride_q <= cmd_stride_i[IDX_W-1:0];
          depth_q  <= DEPTH_W'(1);
          if (op_e'(cmd_op_i) == OP_CLEAR) begin
            idx_q   <= '0;
            state_q <= S_CLEAR;
          end else begin
            idx_q   <= cmd_hash_i[IDX_W-1:0];
            state_q <= S_PROBE;
          end
        end
        S_PROBE: begin
          if (take) begin
            status_q    <= (op_q == OP_INSERT && rd_used && !rep_q) ? ST_EXISTS : ST_OK;
            rsp_idx_q   <= idx_q;
            rsp_depth_q <= depth_q;
            state_q     <= S_DONE;
          end else if (give_up) begin
            status_q    <= (op_q == OP_INSERT) ? ST_BUSY : ST_MISS;
            rsp_idx_q   <= '0;
            rsp_depth_q <= depth_q;
            state_q     <= S_DONE;
          end else begin
            idx_q   <= idx_q + stride_q;
            depth_q <= depth_q + DEPTH_W'(1);
          end
        end
        S_CLEAR: begin
          if (clr_last) begin
            status_q    <= ST_OK;
            rsp_idx_q   <= '0;
            rsp_depth_q <= '0;
            state_q     <= S_DONE;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready_o  = (state_q == S_IDLE);
  assign rsp_valid_o  = (state_q == S_DONE);
  assign rsp_status_o = status_q;
  assign rsp_index_o  = rsp_idx_q;
  assign rsp_depth_o  = rsp_depth_q;
endmodule

// File: rtl/fte_checker.sv
module fte_checker #(
  parameter int MAX_HOPS   = 200,
  parameter int FUDGE_FULL = 1,
  parameter int FUDGE_WILD = 3,
  localparam int DEPTH_W   = $clog2(MAX_HOPS + 1),
  localparam int LIM_W     = DEPTH_W + 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cmd_valid_i,
  input logic               cmd_ready_o,
  input logic               rsp_valid_o,
  input logic [1:0]         rsp_status_o,
  input logic [DEPTH_W-1:0] rsp_depth_o,
  input logic               lim_valid_o,
  input logic [1:0]         lim_type_o,
  input logic [LIM_W-1:0]   lim_value_o
);
  a_r11_rsp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  a_r11_busy_during_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !cmd_ready_o);

  a_r11_ready_after_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> cmd_ready_o);

  a_r1_no_instant_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> !rsp_valid_o);

  a_r8_lim_with_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lim_valid_o |-> (rsp_valid_o && rsp_status_o == 2'd0));

  a_r8_lim_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lim_valid_o |-> lim_value_o == LIM_W'(rsp_depth_o) +
      (lim_type_o[0] ? LIM_W'(FUDGE_WILD) : LIM_W'(FUDGE_FULL)));

  a_r6_busy_depth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o == 2'd1) |-> rsp_depth_o == DEPTH_W'(MAX_HOPS));
endmodule

bind filter_table_engine fte_checker #(
  .MAX_HOPS  (MAX_HOPS),
  .FUDGE_FULL(FUDGE_FULL),
  .FUDGE_WILD(FUDGE_WILD)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_ready_o (cmd_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_status_o(rsp_status_o),
  .rsp_depth_o (rsp_depth_o),
  .lim_valid_o (lim_valid_o),
  .lim_type_o  (lim_type_o),
  .lim_value_o (lim_value_o)
);

// File: tb/tb_filter_table_engine.sv
module tb_filter_table_engine;
  localparam int SIZE = 16;
  localparam int HOPS = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_ready, cmd_rep = 1'b0;
  logic [1:0]  cmd_op = '0, cmd_type = '0;
  logic [95:0] cmd_match = '0;
  logic [11:0] cmd_qid = '0;
  logic [15:0] cmd_hash = '0, cmd_stride = '0;
  logic        rsp_valid, lim_valid;
  logic [1:0]  rsp_status, lim_type;
  logic [3:0]  rsp_index;
  logic [7:0]  rsp_depth;
  logic [8:0]  lim_value;

  int total = 0, bad = 0, cycles = 0;

  bit          m_used [SIZE];
  logic [1:0]  m_type [SIZE];
  logic [95:0] m_match [SIZE];
  logic [11:0] m_qid [SIZE];
  int          m_cnt = 0;
  int          m_max [4];

  filter_table_engine #(.SIZE(SIZE), .MAX_HOPS(HOPS), .TX_DIR(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_op_i(cmd_op),
    .cmd_replace_i(cmd_rep), .cmd_type_i(cmd_type), .cmd_match_i(cmd_match),
    .cmd_qid_i(cmd_qid), .cmd_hash_i(cmd_hash), .cmd_stride_i(cmd_stride),
    .rsp_valid_o(rsp_valid), .rsp_status_o(rsp_status), .rsp_index_o(rsp_index),
    .rsp_depth_o(rsp_depth), .lim_valid_o(lim_valid), .lim_type_o(lim_type),
    .lim_value_o(lim_value)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=0", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run_cmd(input logic [1:0] op, input bit rep, input logic [1:0] ty,
                         input logic [95:0] mw, input logic [11:0] q,
                         input logic [15:0] h, input logic [15:0] st, input string req);
    int e_lat, e_stat, e_idx, e_dep, e_limv, idx, a_stat, a_idx, a_dep, a_limv, a_ltype, bad_cyc;
    bit e_lim, found, was_used;
    e_lim = 0; e_limv = 0; e_idx = 0; e_dep = 0; e_stat = 0; found = 0; bad_cyc = -1;
    a_stat = -1; a_idx = -1; a_dep = -1; a_limv = -1; a_ltype = -1;
    if (op == 2'd3) begin
      e_lat = SIZE;
      for (int s = 0; s < SIZE; s++) m_used[s] = 0;
      m_cnt = 0;
      for (int t = 0; t < 4; t++) m_max[t] = 0;
    end else begin
      idx = int'(h) % SIZE;
      for (int d = 1; d <= HOPS && !found; d++) begin
        bit eq;
        eq = m_used[idx] && m_type[idx] == ty && m_match[idx] == mw && m_qid[idx] == q;
        if (m_used[idx] ? eq : (op == 2'd1)) begin
          found = 1; e_dep = d; e_idx = idx;
        end else idx = (idx + int'(st)) % SIZE;
      end
      if (!found) begin
        e_dep = HOPS; e_lat = HOPS; e_stat = (op == 2'd1) ? 1 : 2;
      end else begin
        e_lat = e_dep;
        was_used = m_used[e_idx];
        if (op == 2'd1) begin
          if (was_used && !rep) e_stat = 3;
          else begin
            if (!was_used) m_cnt++;
            m_used[e_idx] = 1; m_type[e_idx] = ty; m_match[e_idx] = mw; m_qid[e_idx] = q;
            if (e_dep > m_max[ty]) begin
              e_lim = 1; e_limv = e_dep + (ty[0] ? 3 : 1); m_max[ty] = e_dep;
            end
          end
        end else if (op == 2'd2) begin
          m_used[e_idx] = 0; m_cnt--;
          if (m_cnt == 0) for (int t = 0; t < 4; t++) m_max[t] = 0;
        end
      end
    end

    @(negedge clk);
    chk(cmd_ready == 1'b1, "R11", "ready before command", int'(cmd_ready), 1);
    cmd_op = op; cmd_rep = rep; cmd_type = ty; cmd_match = mw; cmd_qid = q;
    cmd_hash = h; cmd_stride = st; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (rsp_valid || lim_valid) bad_cyc = 0;
    for (int k = 1; k <= e_lat + 1; k++) begin
      bit ev;
      @(negedge clk);
      ev = (k == e_lat);
      if (rsp_valid != ev || lim_valid != (ev && e_lim)) if (bad_cyc < 0) bad_cyc = k;
      if (ev) begin
        a_stat = int'(rsp_status); a_idx = int'(rsp_index); a_dep = int'(rsp_depth);
        a_limv = int'(lim_value); a_ltype = int'(lim_type);
      end
      if (k == e_lat + 1 && !cmd_ready) if (bad_cyc < 0) bad_cyc = k;
    end
    chk(bad_cyc < 0, req, "R1 cycle of response/limit pulse (first bad cycle)", bad_cyc, e_lat);
    chk(a_stat == e_stat, req, "status", a_stat, e_stat);
    chk(a_idx == e_idx, req, "index", a_idx, e_idx);
    chk(a_dep == e_dep, req, "depth", a_dep, e_dep);
    if (e_lim) begin
      chk(a_limv == e_limv, req, "R8 limit value", a_limv, e_limv);
      chk(a_ltype == int'(ty), req, "R8 limit type", a_ltype, int'(ty));
    end
  endtask

  initial begin
    for (int t = 0; t < 4; t++) m_max[t] = 0;
    for (int s = 0; s < SIZE; s++) m_used[s] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R11", "reset ready", int'(cmd_ready), 1);
    chk(rsp_valid == 1'b0, "R11", "reset rsp_valid", int'(rsp_valid), 0);
    chk(lim_valid == 1'b0, "R11", "reset lim_valid", int'(lim_valid), 0);

    // A/B/C collide on slot 3 with stride 5: slots 3, 8, 13
    run_cmd(2'd1, 0, 2'd0, 96'hA, 12'd1, 16'hFFF3, 16'd5, "R2");
    run_cmd(2'd1, 0, 2'd0, 96'hA, 12'd1, 16'hFFF3, 16'd5, "R3");
    run_cmd(2'd1, 1, 2'd0, 96'hA, 12'd1, 16'hFFF3, 16'd5, "R3");
    run_cmd(2'd1, 0, 2'd0, 96'hB, 12'd7, 16'h0003, 16'h0015, "R1");
    run_cmd(2'd1, 0, 2'd1, 96'hC, 12'd2, 16'h0003, 16'd5, "R8");
    run_cmd(2'd0, 0, 2'd0, 96'hB, 12'd7, 16'h0003, 16'd5, "R5");
    run_cmd(2'd0, 0, 2'd0, 96'hB, 12'd8, 16'h0003, 16'd5, "R4");
    run_cmd(2'd0, 0, 2'd1, 96'hB, 12'd7, 16'h0003, 16'd5, "R4");
    run_cmd(2'd2, 0, 2'd0, 96'hA, 12'd1, 16'h0003, 16'd5, "R7");
    run_cmd(2'd0, 0, 2'd0, 96'hA, 12'd1, 16'h0003, 16'd5, "R7");
    run_cmd(2'd0, 0, 2'd1, 96'hC, 12'd2, 16'h0003, 16'd5, "R5");
    run_cmd(2'd1, 0, 2'd0, 96'hD, 12'd3, 16'h0003, 16'd5, "R8");
    run_cmd(2'd2, 0, 2'd0, 96'hB, 12'd7, 16'h0003, 16'd5, "R7");
    run_cmd(2'd2, 0, 2'd1, 96'hC, 12'd2, 16'h0003, 16'd5, "R7");
    run_cmd(2'd2, 0, 2'd0, 96'hD, 12'd3, 16'h0003, 16'd5, "R9");
    run_cmd(2'd1, 0, 2'd0, 96'hE, 12'd0, 16'h0000, 16'd1, "R9");
    run_cmd(2'd1, 0, 2'd1, 96'hF, 12'd0, 16'h0005, 16'd1, "R9");
    run_cmd(2'd2, 0, 2'd0, 96'h99, 12'd0, 16'h0000, 16'd1, "R7");
    for (int i = 0; i < SIZE - 2; i++)
      run_cmd(2'd1, 0, 2'd0, 96'(i + 100), 12'd0, 16'h0000, 16'd1, "R6");
    run_cmd(2'd1, 0, 2'd0, 96'h777, 12'd0, 16'h0000, 16'd1, "R6");
    run_cmd(2'd3, 0, 2'd0, 96'h0, 12'd0, 16'h0000, 16'd0, "R10");
    run_cmd(2'd0, 0, 2'd0, 96'hE, 12'd0, 16'h0000, 16'd1, "R10");
    run_cmd(2'd1, 0, 2'd0, 96'h123, 12'd0, 16'h0009, 16'd3, "R10");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule